// File: doc/BRIEF.md
# Serial DMA Word Buffer Controller

This block sits between a serial shift engine and a memory-side DMA requester. It holds a small word FIFO and steers it in one of two directions. In transmit mode the block takes words from memory and supplies them to the serial side on request. In receive mode it collects words from the serial side and offers them to memory. A control word selects the mode and the interrupt sources, and it carries a flush bit. A word counter that software loads limits how many words the memory side may move. There is a single interrupt output.

Both memory-side ports use valid/ready handshakes. A word moves only in a cycle where valid and ready are both high. The inbound port (`mi_*`, transmit mode) raises `mi_ready` only when the FIFO has room and the word count is not zero. The outbound port (`mo_*`, receive mode) keeps `mo_valid` and `mo_data` steady until `mo_ready` is seen. The serial side cannot be held off. A word offered on `ser_rx_valid` while the FIFO is full is an overflow. A `ser_tx_req` while the FIFO is empty is an underrun. Each of these sets a sticky flag.

Control word bit positions: 0 enable, 1 direction (0 transmit, 1 receive), 2 completion-interrupt enable, 4 chaining flag (stored and read back only), 7 flush, 8 error-interrupt enable, 9 receive-overflow flag, 10 transmit-underrun flag. Bits 3, 5 and 6 are reserved.

Top module: `serdma_buf_ctrl`

## Requirements
- R1: After reset `cfg_rdata`, `cnt_rdata`, `irq`, `mi_ready`, `mo_valid` and `ser_tx_data` are all zero.
- R2: A control write stores bits 0, 1, 2, 4, 7 and 8, which read back unchanged. Bits 3, 5 and 6 always read 0.
- R3: The FIFO holds four words. In transmit mode, after four accepted words with no serial request, `mi_ready` is low.
- R4: In transmit mode each `ser_tx_req` on a non-empty FIFO places the oldest word on `ser_tx_data` from the next cycle on. Words leave in the order they were accepted.
- R5: A `ser_tx_req` in transmit mode with the FIFO empty sets bit 10 and leaves `ser_tx_data` at the last word sent.
- R6: In receive mode serial words reach `mo_data` in arrival order. While `mo_valid` is high and `mo_ready` is low, `mo_data` holds steady.
- R7: A serial word offered in receive mode while four words are buffered sets bit 9. That word is dropped and the buffered words are kept.
- R8: Bits 9 and 10 stay set until a control write with a 1 in that position. A write with 0 there leaves the flag unchanged.
- R9: While bit 7 is 1 the FIFO is emptied and all pushes, pops and serial requests are ignored: no flag changes, `mi_ready` and `mo_valid` stay low, and the count does not change. Bit 7 stays 1 until a write of 0.
- R10: `cnt_rdata` takes the value of a `cnt_we` write and drops by one for each word moved on the memory side. At zero, `mi_ready` and `mo_valid` stay low.
- R11: With bit 2 set, the count reaching zero gives a one-cycle high on `irq` in the next cycle.
- R12: With bit 8 set, `irq` is high for as long as bit 9 or bit 10 is set. With bit 8 clear, the flags do not raise `irq`.
- R13: With bit 0 clear, memory-side and serial-side inputs have no effect on the flags, the count or the handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 11 | Control word write data |
| cfg_rdata | output | 11 | Control and status readback |
| cnt_we | input | 1 | Word count load strobe |
| cnt_wdata | input | CNT_W | Word count load value |
| cnt_rdata | output | CNT_W | Remaining word count |
| mi_valid | input | 1 | Memory word offered (transmit) |
| mi_ready | output | 1 | Buffer accepts memory word |
| mi_data | input | DATA_W | Memory word (transmit) |
| mo_valid | output | 1 | Buffered word offered to memory (receive) |
| mo_ready | input | 1 | Memory accepts word |
| mo_data | output | DATA_W | Word to memory (receive) |
| ser_rx_valid | input | 1 | Serial side delivers a received word |
| ser_rx_data | input | DATA_W | Received serial word |
| ser_tx_req | input | 1 | Serial side asks for the next word |
| ser_tx_data | output | DATA_W | Word given to the serial side |
| irq | output | 1 | Completion or error interrupt |

## Verification
The bench builds the block with its default values: 32-bit words, a four-entry FIFO and a 16-bit count. A depth of four keeps the full and empty boundaries only a few cycles apart, so overflow, underrun and full back-pressure can each be reached in short directed sequences. A table of mixed-direction single-word transfers, each with a count of one, drives the count to zero on every entry, so the completion pulse and the stop at zero are checked repeatedly.

// File: rtl/serdma_pkg.sv
package serdma_pkg;
  localparam int CTL_W     = 11;
  localparam int B_EN      = 0;
  localparam int B_DIR     = 1;
  localparam int B_DONE_IE = 2;
  localparam int B_CHAIN   = 4;
  localparam int B_FLUSH   = 7;
  localparam int B_ERR_IE  = 8;
  localparam int B_OVF     = 9;
  localparam int B_UNF     = 10;
endpackage

// File: rtl/serdma_regs.sv
module serdma_regs
  import serdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  input  logic             set_ovf,
  input  logic             set_unf,
  output logic             en,
  output logic             dir,
  output logic             done_ie,
  output logic             err_ie,
  output logic             flush,
  output logic             ovf,
  output logic             unf,
  output logic [CTL_W-1:0] cfg_rdata
);
  logic chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; dir <= 1'b0; done_ie <= 1'b0;
      err_ie <= 1'b0; flush <= 1'b0; chain <= 1'b0;
    end else if (cfg_we) begin
      en      <= cfg_wdata[B_EN];
      dir     <= cfg_wdata[B_DIR];
      done_ie <= cfg_wdata[B_DONE_IE];
      chain   <= cfg_wdata[B_CHAIN];
      flush   <= cfg_wdata[B_FLUSH];
      err_ie  <= cfg_wdata[B_ERR_IE];
    end
  end

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= set_ovf | (ovf & ~(cfg_we & cfg_wdata[B_OVF]));
      unf <= set_unf | (unf & ~(cfg_we & cfg_wdata[B_UNF]));
    end
  end

  always_comb begin
    cfg_rdata            = '0;
    cfg_rdata[B_EN]      = en;
    cfg_rdata[B_DIR]     = dir;
    cfg_rdata[B_DONE_IE] = done_ie;
    cfg_rdata[B_CHAIN]   = chain;
    cfg_rdata[B_FLUSH]   = flush;
    cfg_rdata[B_ERR_IE]  = err_ie;
    cfg_rdata[B_OVF]     = ovf;
    cfg_rdata[B_UNF]     = unf;
  end

  // R8: a flag only drops on a write of 1 to its position
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(cfg_we && cfg_wdata[B_OVF]) |=> ovf);
  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !(cfg_we && cfg_wdata[B_UNF]) |=> unf);
  // R9: flush bit holds until rewritten
  a_r9_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !cfg_we |=> flush);
endmodule

// File: rtl/serdma_fifo.sv
module serdma_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    occ;
  logic             push_ok, pop_ok;

  assign full    = (occ == CW'(DEPTH));
  assign empty   = (occ == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign rdata   = mem[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (push_ok && wr_ptr == PW'(g))   mem[g] <= wdata;
    end
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; occ <= '0;
    end else if (flush) begin
      wr_ptr <= '0; rd_ptr <= '0; occ <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      occ <= occ + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R3: the controller never offers a word to a full buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R9: flush leaves the buffer empty
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/serdma_xcnt.sv
module serdma_xcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             zero,
  output logic             done
);
  assign zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= dec & ~load & (count == CNT_W'(1));
      if (load)     count <= load_val;
      else if (dec) count <= count - 1'b1;
    end
  end

  // R10: one word moved means one step down
  a_r10_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !load |=> count == $past(count) - 1'b1);
  a_r10_no_dec_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
  // R11: completion is a single-cycle event
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/serdma_buf_ctrl.sv
module serdma_buf_ctrl
  import serdma_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTL_W-1:0]  cfg_wdata,
  output logic [CTL_W-1:0]  cfg_rdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_rdata,
  input  logic              mi_valid,
  output logic              mi_ready,
  input  logic [DATA_W-1:0] mi_data,
  output logic              mo_valid,
  input  logic              mo_ready,
  output logic [DATA_W-1:0] mo_data,
  input  logic              ser_rx_valid,
  input  logic [DATA_W-1:0] ser_rx_data,
  input  logic              ser_tx_req,
  output logic [DATA_W-1:0] ser_tx_data,
  output logic              irq
);
  logic en, dir, done_ie, err_ie, flush, ovf, unf;
  logic tx_mode, rx_mode;
  logic f_full, f_empty, f_push, f_pop;
  logic [DATA_W-1:0] f_wdata, f_rdata;
  logic cnt_zero, cnt_done;
  logic mi_fire, mo_fire, rx_push, tx_pop, set_ovf, set_unf;

  serdma_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_wdata,
    .set_ovf, .set_unf,
    .en, .dir, .done_ie, .err_ie, .flush, .ovf, .unf,
    .cfg_rdata
  );

  assign tx_mode = en & ~dir & ~flush;
  assign rx_mode = en &  dir & ~flush;

  assign mi_ready = tx_mode & ~cnt_zero & ~f_full;
  assign mi_fire  = mi_valid & mi_ready;
  assign mo_valid = rx_mode & ~cnt_zero & ~f_empty;
  assign mo_fire  = mo_valid & mo_ready;

  assign rx_push = rx_mode & ser_rx_valid & ~f_full;
  assign set_ovf = rx_mode & ser_rx_valid &  f_full;
  assign tx_pop  = tx_mode & ser_tx_req & ~f_empty;
  assign set_unf = tx_mode & ser_tx_req &  f_empty;

  assign f_push  = mi_fire | rx_push;
  assign f_pop   = tx_pop | mo_fire;
  assign f_wdata = dir ? ser_rx_data : mi_data;

  serdma_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .flush,
    .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .rdata(f_rdata),
    .full(f_full), .empty(f_empty)
  );

  serdma_xcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n,
    .load(cnt_we), .load_val(cnt_wdata),
    .dec(mi_fire | mo_fire),
    .count(cnt_rdata), .zero(cnt_zero), .done(cnt_done)
  );

  // serial output register: repeats the previous word on underrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ser_tx_data <= '0;
    else if (tx_pop) ser_tx_data <= f_rdata;
  end

  assign mo_data = f_rdata;
  assign irq     = (cnt_done & done_ie) | ((ovf | unf) & err_ie);

  // R5: underrun leaves the serial word untouched
  a_r5_unf_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    set_unf |=> $stable(ser_tx_data));
  // R6: an offered word is held until taken
  a_r6_mo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mo_valid && !mo_ready && !cfg_we && !cnt_we |=> mo_valid && $stable(mo_data));
  // R7: overflow never shrinks the buffer
  a_r7_ovf_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> !f_empty);
  // R13: a disabled block moves nothing
  a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !f_push && !f_pop && !set_ovf && !set_unf);
endmodule

// File: tb/serdma_buf_ctrl_tb_top.sv
module serdma_buf_ctrl_tb_top;
  localparam int DW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic [10:0] cfg_rdata;
  logic cnt_we = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] cnt_rdata;
  logic mi_valid = 1'b0, mi_ready;
  logic [DW-1:0] mi_data = '0;
  logic mo_valid, mo_ready = 1'b0;
  logic [DW-1:0] mo_data;
  logic ser_rx_valid = 1'b0;
  logic [DW-1:0] ser_rx_data = '0;
  logic ser_tx_req = 1'b0;
  logic [DW-1:0] ser_tx_data;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  serdma_buf_ctrl dut_i (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata,
    .cnt_we, .cnt_wdata, .cnt_rdata,
    .mi_valid, .mi_ready, .mi_data,
    .mo_valid, .mo_ready, .mo_data,
    .ser_rx_valid, .ser_rx_data, .ser_tx_req, .ser_tx_data,
    .irq
  );

  // entry: {direction, word}; direction 0 = transmit, 1 = receive
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 32'hDEAD_0001}, {1'b1, 32'h1234_5678},
    {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h0000_0000},
    {1'b1, 32'hA5A5_5A5A}, {1'b0, 32'h8000_0001},
    {1'b0, 32'h0F0F_F0F0}, {1'b1, 32'h7777_3333}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [10:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CW-1:0] v);
    cnt_we = 1'b1; cnt_wdata = v; tick(); cnt_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a [4];
    logic [31:0] b [5];
    a = '{32'hA000_0000, 32'hA111_1111, 32'hA222_2222, 32'hA333_3333};
    b = '{32'hB000_0000, 32'hB111_1111, 32'hB222_2222, 32'hB333_3333, 32'hB444_4444};

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cfg", 32'(cfg_rdata), 0);
    chk("R1 cnt", 32'(cnt_rdata), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mi_ready", 32'(mi_ready), 0);
    chk("R1 mo_valid", 32'(mo_valid), 0);
    chk("R1 tx_data", ser_tx_data, 0);
    rst_n = 1'b1;
    tick();

    // R2 readback and reserved bits
    wr_cfg(11'h7FF);
    chk("R2 all-ones readback", 32'(cfg_rdata), 32'h197);
    wr_cfg(11'h000);
    chk("R2 clear readback", 32'(cfg_rdata), 0);

    // table walk: one word per entry, count of one, completion pulse
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = VEC[i][31:0];
      if (!VEC[i][32]) begin
        wr_cfg(11'h005);
        wr_cnt(16'd1);
        mi_valid = 1'b1; mi_data = w; #1;
        chk("R10 ready with count", 32'(mi_ready), 1);
        tick(); mi_valid = 1'b0; #1;
        chk("R11 done pulse tx", 32'(irq), 1);
        chk("R10 stop at zero tx", 32'(mi_ready), 0);
        chk("R10 count zero", 32'(cnt_rdata), 0);
        tick();
        chk("R11 pulse ends", 32'(irq), 0);
        ser_tx_req = 1'b1; tick(); ser_tx_req = 1'b0;
        chk("R4 tx word", ser_tx_data, w);
      end else begin
        wr_cfg(11'h007);
        wr_cnt(16'd1);
        ser_rx_valid = 1'b1; ser_rx_data = w; tick(); ser_rx_valid = 1'b0; #1;
        chk("R6 mo_valid", 32'(mo_valid), 1);
        chk("R6 rx word", mo_data, w);
        mo_ready = 1'b1; tick(); mo_ready = 1'b0; #1;
        chk("R11 done pulse rx", 32'(irq), 1);
        chk("R10 stop at zero rx", 32'(mo_valid), 0);
        tick();
        chk("R11 pulse ends", 32'(irq), 0);
      end
    end
    wr_cfg(11'h000);

    // R3/R4/R5: fill in transmit mode, drain, underrun
    wr_cfg(11'h001);
    wr_cnt(16'd10);
    mi_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      mi_data = a[i]; tick();
    end
    #1;
    chk("R3 full back-pressure", 32'(mi_ready), 0);
    chk("R10 count after four", 32'(cnt_rdata), 6);
    mi_valid = 1'b0;
    ser_tx_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R4 order", ser_tx_data, a[i]);
    end
    tick(); ser_tx_req = 1'b0;
    chk("R5 repeat last", ser_tx_data, a[3]);
    chk("R5 underrun flag", 32'(cfg_rdata), 32'h401);
    #1;
    chk("R3 room again", 32'(mi_ready), 1);

    // R12/R8: error interrupt and sticky clear
    chk("R12 masked", 32'(irq), 0);
    wr_cfg(11'h101);
    chk("R12 error irq", 32'(irq), 1);
    chk("R8 write 0 keeps flag", 32'(cfg_rdata), 32'h501);
    wr_cfg(11'h501);
    chk("R8 write 1 clears", 32'(cfg_rdata), 32'h101);
    chk("R12 irq drops", 32'(irq), 0);

    // R7/R6: receive overflow, back-pressure, drain
    wr_cfg(11'h003);
    wr_cnt(16'd10);
    ser_rx_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_rx_data = b[i]; tick();
    end
    ser_rx_valid = 1'b0;
    chk("R7 overflow flag", 32'(cfg_rdata), 32'h203);
    chk("R6 head held", mo_data, b[0]);
    tick();
    chk("R6 stable under back-pressure", mo_data, b[0]);
    mo_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R7 kept words in order", mo_data, b[i]);
      tick();
    end
    mo_ready = 1'b0;
    chk("R7 dropped word absent", 32'(mo_valid), 0);
    chk("R10 count after rx", 32'(cnt_rdata), 6);
    wr_cfg(11'h203);
    chk("R8 clear overflow", 32'(cfg_rdata), 32'h003);

    // R9: flush
    wr_cfg(11'h001);
    wr_cnt(16'd10);
    mi_valid = 1'b1;
    mi_data = 32'hC000_0000; tick();
    mi_data = 32'hC111_1111; tick();
    mi_valid = 1'b0;
    wr_cfg(11'h081);
    chk("R9 flush readback", 32'(cfg_rdata), 32'h081);
    mi_valid = 1'b1; #1;
    chk("R9 no accept", 32'(mi_ready), 0);
    tick(); mi_valid = 1'b0;
    ser_tx_req = 1'b1; tick(); ser_tx_req = 1'b0;
    chk("R9 request ignored", 32'(cfg_rdata), 32'h081);
    chk("R9 tx word unchanged", ser_tx_data, a[3]);
    chk("R9 count unchanged", 32'(cnt_rdata), 8);
    tick();
    chk("R9 bit stays set", 32'(cfg_rdata), 32'h081);
    wr_cfg(11'h001);
    ser_tx_req = 1'b1; tick(); ser_tx_req = 1'b0;
    chk("R9 buffer was emptied", 32'(cfg_rdata), 32'h401);
    chk("R9 no flushed word sent", ser_tx_data, a[3]);
    wr_cfg(11'h400);
    chk("R8 cleared and disabled", 32'(cfg_rdata), 0);

    // R13: disabled
    mi_valid = 1'b1; ser_rx_valid = 1'b1; ser_tx_req = 1'b1; mo_ready = 1'b1; #1;
    chk("R13 no accept", 32'(mi_ready), 0);
    chk("R13 no offer", 32'(mo_valid), 0);
    tick();
    mi_valid = 1'b0; ser_rx_valid = 1'b0; ser_tx_req = 1'b0; mo_ready = 1'b0;
    chk("R13 flags untouched", 32'(cfg_rdata), 0);
    chk("R13 count untouched", 32'(cnt_rdata), 8);
    chk("R13 irq low", 32'(irq), 0);

    finish_run();
  end
endmodule